// File: doc/BRIEF.md
# Dual-Protocol Serial Register Slave

This block gives a host access to a small internal register file over one set of serial pads. The level on the protocol-select input decides which engine owns the pads. When it is high, the block is an I2C target on the clock and data pads. When it is low, the block is an SPI target. The block never drives the clock and never starts or ends a transfer. Registers can be written and read back over either protocol.

In SPI mode, one bit of a configuration register picks how read data leaves the block. In 4-wire operation a dedicated output pad carries it. In 3-wire operation the shared data pad turns around and drives the read data once the command byte is done. All pad inputs are sampled by the system clock through a synchronizer, so the engines are ordinary clocked state machines that detect pad edges. This holds at the 100 kHz and 400 kHz I2C rates, provided the system clock is much faster than the serial clock.

Top module: `sr_dual_slave`

## Requirements
- R1: With `cs_i` high the block acts only as an I2C target. `sdo_oe_o` stays low. The data pad is open-drain: whenever `sda_oe_o` is high, `sda_o` is 0, and the I2C engine pulls the pad only while it is selected.
- R2: After a START, the block acknowledges (holds SDA low in the ninth clock) only a first byte whose upper seven bits equal `DEV_ADDR` (default 7'h1D). Any other address gets no acknowledge, and the following bytes change no register.
- R3: In an I2C write, the first byte after the address byte sets the register pointer. Each later byte is written to the register the pointer selects and is acknowledged. The pointer then advances by one, modulo the register count.
- R4: After a repeated START with the R/W bit (LSB of the address byte) at 1, the block sends registers MSB first from the pointer and advances after each byte. When the master does not acknowledge, the block releases SDA and stays silent until the next START.
- R5: The first SPI byte is a command: bit 7 is 1 for read and 0 for write, bit 6 is 1 for auto-increment, and bits 5:0 are the register address. The serial clock idles high. Input is sampled on its rising edge, output changes on its falling edge, and data goes MSB first.
- R6: In an SPI transfer with bit 6 of the command at 0, every data byte goes to or comes from the same register.
- R7: Bit 0 of the register at `CFG_ADDR` (default 6'h20) selects 3-wire SPI when 1 and 4-wire SPI when 0. It is writable over either protocol.
- R8: In 4-wire SPI, read data appears on `sdo_o`. `sdo_oe_o` is high only while `cs_i` is low, and `sda_oe_o` stays low.
- R9: In 3-wire SPI, `sda_oe_o` stays low through the whole command byte. It goes high from the first data bit of a read and drops once `cs_i` rises. `sdo_oe_o` stays low.
- R10: After reset, every register reads 0 and no output enable is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample all pads |
| rst_n | input | 1 | Active-low reset |
| cs_i | input | 1 | Protocol select: 1 = I2C, 0 = SPI transfer active |
| scl_i | input | 1 | Serial clock pad (I2C clock or SPI clock) |
| sda_i | input | 1 | Shared data pad, input side |
| sda_o | output | 1 | Shared data pad, value driven when enabled |
| sda_oe_o | output | 1 | Shared data pad output enable |
| sdo_o | output | 1 | Dedicated SPI read-data pad value |
| sdo_oe_o | output | 1 | Dedicated SPI read-data pad output enable |

## Verification
The bench builds the block with its default parameters: a 6-bit register address (64 registers of 8 bits), target address 7'h1D, the configuration register at 6'h20 and a two-stage synchronizer. At that size every register can be written by an I2C burst and read back through an I2C burst, a 4-wire SPI burst and a 3-wire SPI burst, with values from an arithmetic pattern. The sweep covers wrap-around of the auto-increment pointer and the switch between pad modes. It also covers a wrong I2C address and a master NACK, the non-incrementing SPI transfer and reset contents.

// File: rtl/sr_pkg.sv
package sr_pkg;
   localparam int BYTE_W = 8;

   typedef enum logic [2:0] {
      I_IDLE,
      I_ADDR,
      I_AACK,
      I_WR,
      I_WACK,
      I_RD,
      I_RACK
   } i2c_st_e;
endpackage

// File: rtl/sr_sync.sv
module sr_sync #(
   parameter int             W       = 1,
   parameter int             STAGES  = 2,
   parameter logic [W-1:0]   RST_VAL = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   initial assert (STAGES >= 0 && STAGES <= 4) else $error("sr_sync: STAGES out of range");

   if (STAGES == 0) begin : g_bypass
      assign q = d;
   end else begin : g_chain
      logic [W-1:0] ff [STAGES];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) ff[i] <= RST_VAL;
         end else begin
            ff[0] <= d;
            for (int i = 1; i < STAGES; i++) ff[i] <= ff[i-1];
         end
      end
      assign q = ff[STAGES-1];
   end
endmodule

// File: rtl/sr_regfile.sv
module sr_regfile #(
   parameter int            AW       = 6,
   parameter int            DW       = 8,
   parameter logic [AW-1:0] CFG_ADDR = 6'h20
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata,
   output logic          three_wire
);
   localparam int NREG = 1 << AW;

   initial assert (AW >= 1 && AW <= 8) else $error("sr_regfile: AW out of range");

   logic [DW-1:0] mem [NREG];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NREG; i++) mem[i] <= '0;
      end else if (we) begin
         mem[waddr] <= wdata;
      end
   end

   assign rdata      = mem[raddr];
   assign three_wire = mem[CFG_ADDR][0];

   // R7
   cfg_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (we && waddr == CFG_ADDR) |=> (three_wire == $past(wdata[0])));
endmodule

// File: rtl/sr_i2c.sv
module sr_i2c
   import sr_pkg::*;
#(
   parameter int            AW       = 6,
   parameter logic [6:0]    DEV_ADDR = 7'h1D
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              scl,
   input  logic              sda,
   input  logic [BYTE_W-1:0] rdata,
   output logic [AW-1:0]     raddr,
   output logic              we,
   output logic [AW-1:0]     waddr,
   output logic [BYTE_W-1:0] wdata,
   output logic              pull
);
   initial assert (AW <= BYTE_W) else $error("sr_i2c: pointer wider than a byte");

   i2c_st_e           st;
   logic              scl_q, sda_q, rw, first, nack;
   logic [3:0]        cnt;
   logic [BYTE_W-1:0] shreg, tx;
   logic [AW-1:0]     ptr;
   logic              rise, fall, start_c, stop_c;

   assign rise    = en &  scl & ~scl_q;
   assign fall    = en & ~scl &  scl_q;
   assign start_c = en & scl & scl_q &  sda_q & ~sda;
   assign stop_c  = en & scl & scl_q & ~sda_q &  sda;
   assign raddr   = ptr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= I_IDLE; scl_q <= 1'b1; sda_q <= 1'b1; rw <= 1'b0; first <= 1'b0;
         nack <= 1'b0; cnt <= '0; shreg <= '0; tx <= '0; ptr <= '0;
         pull <= 1'b0; we <= 1'b0; waddr <= '0; wdata <= '0;
      end else begin
         scl_q <= scl;
         sda_q <= sda;
         we    <= 1'b0;
         if (!en) begin
            st <= I_IDLE; pull <= 1'b0;
         end else if (start_c) begin
            st <= I_ADDR; cnt <= '0; pull <= 1'b0;
         end else if (stop_c) begin
            st <= I_IDLE; pull <= 1'b0;
         end else begin
            unique case (st)
               I_ADDR, I_WR: begin
                  if (rise) begin
                     shreg <= {shreg[BYTE_W-2:0], sda};
                     cnt   <= cnt + 4'd1;
                  end else if (fall && cnt == 4'd8) begin
                     if (st == I_ADDR) begin
                        if (shreg[7:1] == DEV_ADDR) begin
                           st <= I_AACK; pull <= 1'b1; rw <= shreg[0];
                        end else begin
                           st <= I_IDLE;
                        end
                     end else begin
                        st <= I_WACK; pull <= 1'b1;
                        if (first) begin
                           ptr <= shreg[AW-1:0]; first <= 1'b0;
                        end else begin
                           we <= 1'b1; waddr <= ptr; wdata <= shreg; ptr <= ptr + AW'(1);
                        end
                     end
                  end
               end
               I_AACK: if (fall) begin
                  cnt <= '0;
                  if (rw) begin
                     st <= I_RD; tx <= rdata; pull <= ~rdata[BYTE_W-1];
                  end else begin
                     st <= I_WR; pull <= 1'b0; first <= 1'b1;
                  end
               end
               I_WACK: if (fall) begin
                  st <= I_WR; pull <= 1'b0; cnt <= '0;
               end
               I_RD: if (fall) begin
                  if (cnt == 4'd7) begin
                     st <= I_RACK; pull <= 1'b0; ptr <= ptr + AW'(1);
                  end else begin
                     cnt  <= cnt + 4'd1;
                     tx   <= {tx[BYTE_W-2:0], 1'b0};
                     pull <= ~tx[BYTE_W-2];
                  end
               end
               I_RACK: begin
                  if (rise) nack <= sda;
                  else if (fall) begin
                     if (nack) begin
                        st <= I_IDLE; pull <= 1'b0;
                     end else begin
                        st <= I_RD; cnt <= '0; tx <= rdata; pull <= ~rdata[BYTE_W-1];
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

   // R1
   i2c_deselect_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !pull);
   // R2
   i2c_start_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_c |=> !pull);
   // R3
   i2c_write_in_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      we |-> (st == I_WACK && pull));
endmodule

// File: rtl/sr_spi.sv
module sr_spi
   import sr_pkg::*;
#(
   parameter int AW = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              sck,
   input  logic              din,
   input  logic [BYTE_W-1:0] rdata,
   output logic [AW-1:0]     raddr,
   output logic              we,
   output logic [AW-1:0]     waddr,
   output logic [BYTE_W-1:0] wdata,
   output logic              drv,
   output logic              dout
);
   localparam int CMD_AW = BYTE_W - 2;

   initial assert (AW <= CMD_AW) else $error("sr_spi: address wider than command field");

   logic              sck_q, data_ph, rw, ms;
   logic [2:0]        bcnt;
   logic [BYTE_W-2:0] sh;
   logic [BYTE_W-1:0] tx;
   logic [AW-1:0]     addr;
   logic [BYTE_W-1:0] byte_in;
   logic              rise, fall;

   assign rise    = en &  sck & ~sck_q;
   assign fall    = en & ~sck &  sck_q;
   assign byte_in = {sh, din};
   assign raddr   = addr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_q <= 1'b1; data_ph <= 1'b0; rw <= 1'b0; ms <= 1'b0; bcnt <= '0; sh <= '0;
         tx <= '0; addr <= '0; drv <= 1'b0; dout <= 1'b0; we <= 1'b0; waddr <= '0; wdata <= '0;
      end else begin
         sck_q <= sck;
         we    <= 1'b0;
         if (!en) begin
            bcnt <= '0; data_ph <= 1'b0; rw <= 1'b0; drv <= 1'b0;
         end else begin
            if (rise) begin
               sh   <= byte_in[BYTE_W-2:0];
               bcnt <= bcnt + 3'd1;
               if (bcnt == 3'd7) begin
                  if (!data_ph) begin
                     data_ph <= 1'b1;
                     rw      <= byte_in[BYTE_W-1];
                     ms      <= byte_in[BYTE_W-2];
                     addr    <= byte_in[AW-1:0];
                  end else begin
                     if (!rw) begin
                        we <= 1'b1; waddr <= addr; wdata <= byte_in;
                     end
                     if (ms) addr <= addr + AW'(1);
                  end
               end
            end
            if (fall && data_ph && rw) begin
               drv <= 1'b1;
               if (bcnt == 3'd0) begin
                  dout <= rdata[BYTE_W-1];
                  tx   <= {rdata[BYTE_W-2:0], 1'b0};
               end else begin
                  dout <= tx[BYTE_W-1];
                  tx   <= {tx[BYTE_W-2:0], 1'b0};
               end
            end
         end
      end
   end

   // R9
   spi_deselect_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !drv);
   // R9
   spi_drive_after_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      drv |-> (data_ph && rw));
   // R5
   spi_write_at_byte_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      we |-> ($past(rise) && !rw && bcnt == 3'd0));
endmodule

// File: rtl/sr_dual_slave.sv
module sr_dual_slave
   import sr_pkg::*;
#(
   parameter int            AW       = 6,
   parameter logic [6:0]    DEV_ADDR = 7'h1D,
   parameter logic [AW-1:0] CFG_ADDR = 6'h20,
   parameter int            SYNC     = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_i,
   input  logic scl_i,
   input  logic sda_i,
   output logic sda_o,
   output logic sda_oe_o,
   output logic sdo_o,
   output logic sdo_oe_o
);
   logic              cs_s, scl_s, sda_s, i2c_mode, three_wire;
   logic [BYTE_W-1:0] rdata;
   logic [AW-1:0]     i_raddr, i_waddr, s_raddr, s_waddr, raddr, waddr;
   logic [BYTE_W-1:0] i_wdata, s_wdata, wdata;
   logic              i_we, s_we, we, i_pull, s_drv, s_dout;

   sr_sync #(.W(3), .STAGES(SYNC), .RST_VAL(3'b111)) u_sync (
      .clk(clk), .rst_n(rst_n), .d({cs_i, scl_i, sda_i}), .q({cs_s, scl_s, sda_s}));

   assign i2c_mode = cs_s;

   sr_i2c #(.AW(AW), .DEV_ADDR(DEV_ADDR)) u_i2c (
      .clk(clk), .rst_n(rst_n), .en(i2c_mode), .scl(scl_s), .sda(sda_s), .rdata(rdata),
      .raddr(i_raddr), .we(i_we), .waddr(i_waddr), .wdata(i_wdata), .pull(i_pull));

   sr_spi #(.AW(AW)) u_spi (
      .clk(clk), .rst_n(rst_n), .en(~i2c_mode), .sck(scl_s), .din(sda_s), .rdata(rdata),
      .raddr(s_raddr), .we(s_we), .waddr(s_waddr), .wdata(s_wdata), .drv(s_drv), .dout(s_dout));

   assign we    = i2c_mode ? i_we    : s_we;
   assign waddr = i2c_mode ? i_waddr : s_waddr;
   assign wdata = i2c_mode ? i_wdata : s_wdata;
   assign raddr = i2c_mode ? i_raddr : s_raddr;

   sr_regfile #(.AW(AW), .DW(BYTE_W), .CFG_ADDR(CFG_ADDR)) u_regs (
      .clk(clk), .rst_n(rst_n), .we(we), .waddr(waddr), .wdata(wdata),
      .raddr(raddr), .rdata(rdata), .three_wire(three_wire));

   assign sda_oe_o = i2c_mode ? i_pull : (three_wire & s_drv);
   assign sda_o    = ~i2c_mode & s_dout;
   assign sdo_oe_o = ~i2c_mode & ~three_wire;
   assign sdo_o    = s_dout;

   // R8
   pads_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(sda_oe_o && sdo_oe_o));
   // R1
   i2c_no_sdo_chk: assert property (@(posedge clk) disable iff (!rst_n)
      i_pull |-> !sdo_oe_o);
endmodule

// File: tb/test_sr_dual_slave.sv
module test_sr_dual_slave;
   localparam int CLK_PERIOD = 10;
   localparam int Q          = 8;
   localparam int NREG       = 64;
   localparam logic [6:0] DEV = 7'h1D;
   localparam logic [5:0] CFG = 6'h20;

   logic clk = 1'b0, rst_n = 1'b0;
   logic cs = 1'b1, scl_m = 1'b1, sda_m = 1'b1, mosi = 1'b1;
   logic sda_o, sda_oe_o, sdo_o, sdo_oe_o, sda_bus;
   int   checks = 0, fails = 0;
   bit   tw_b = 1'b0;
   logic [7:0] model [NREG];
   logic [7:0] wbuf [NREG];

   always #(CLK_PERIOD/2) clk = ~clk;

   assign sda_bus = cs ? (sda_m & ~(sda_oe_o & ~sda_o)) : (sda_oe_o ? sda_o : mosi);

   sr_dual_slave i_sr_dual_slave (
      .clk(clk), .rst_n(rst_n), .cs_i(cs), .scl_i(scl_m), .sda_i(sda_bus),
      .sda_o(sda_o), .sda_oe_o(sda_oe_o), .sdo_o(sdo_o), .sdo_oe_o(sdo_oe_o));

   function automatic logic [7:0] pat(int i, int salt);
      logic [7:0] v = 8'(i * 37 + salt);
      if (i == int'(CFG)) v[0] = 1'b0;
      return v;
   endfunction

   task automatic w(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic report();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   endtask

   // ---------------- I2C master ----------------
   task automatic i2c_start();
      sda_m = 1; w(Q); scl_m = 1; w(Q); sda_m = 0; w(Q); scl_m = 0; w(Q);
   endtask
   task automatic i2c_stop();
      sda_m = 0; w(Q); scl_m = 1; w(Q); sda_m = 1; w(Q);
   endtask
   task automatic i2c_wbyte(input logic [7:0] b, output logic ack);
      for (int i = 7; i >= 0; i--) begin
         sda_m = b[i]; w(Q); scl_m = 1; w(2*Q); scl_m = 0; w(Q);
      end
      sda_m = 1; w(Q); scl_m = 1; w(Q); ack = sda_bus; w(Q); scl_m = 0; w(Q);
   endtask
   task automatic i2c_rbyte(input bit nack, output logic [7:0] b);
      sda_m = 1;
      for (int i = 7; i >= 0; i--) begin
         w(Q); scl_m = 1; w(Q); b[i] = sda_bus; w(Q); scl_m = 0;
      end
      w(Q); sda_m = nack; w(Q); scl_m = 1; w(2*Q); scl_m = 0; w(Q); sda_m = 1;
   endtask

   task automatic i2c_write(input logic [6:0] dev, input int ptr, input int n);
      logic ack;
      i2c_start();
      i2c_wbyte({dev, 1'b0}, ack);
      chk("R2 address ack", {7'd0, ack}, (dev == DEV) ? 8'd0 : 8'd1);
      if (dev == DEV) begin
         i2c_wbyte(8'(ptr), ack);
         chk("R3 pointer ack", {7'd0, ack}, 8'd0);
         for (int k = 0; k < n; k++) begin
            i2c_wbyte(wbuf[k], ack);
            chk("R3 data ack", {7'd0, ack}, 8'd0);
            model[(ptr + k) % NREG] = wbuf[k];
         end
      end
      i2c_stop();
   endtask

   task automatic i2c_read(input int ptr, input int n);
      logic ack;
      logic [7:0] b;
      i2c_start();
      i2c_wbyte({DEV, 1'b0}, ack);
      i2c_wbyte(8'(ptr), ack);
      i2c_start();
      i2c_wbyte({DEV, 1'b1}, ack);
      chk("R4 read address ack", {7'd0, ack}, 8'd0);
      for (int k = 0; k < n; k++) begin
         i2c_rbyte(k == n - 1, b);
         chk("R4 read data", b, model[(ptr + k) % NREG]);
         chk("R1 sdo idle in I2C", {7'd0, sdo_oe_o}, 8'd0);
      end
      chk("R4 release after nack", {7'd0, sda_oe_o}, 8'd0);
      i2c_stop();
   endtask

   // ---------------- SPI master (clock idles high) ----------------
   task automatic spi_byte(input logic [7:0] tb, input bit cmd, output logic [7:0] rb);
      for (int i = 7; i >= 0; i--) begin
         scl_m = 0; mosi = tb[i]; w(2*Q);
         rb[i] = tw_b ? sda_bus : sdo_o;
         if (cmd) chk("R9 no drive during command", {7'd0, sda_oe_o}, 8'd0);
         scl_m = 1; w(2*Q);
      end
   endtask

   task automatic spi_end();
      mosi = 1; cs = 1; w(2*Q);
      chk("R9 data pad released", {7'd0, sda_oe_o}, 8'd0);
      chk("R8 sdo released", {7'd0, sdo_oe_o}, 8'd0);
   endtask

   task automatic spi_read(input int addr, input int n, input bit ms);
      logic [7:0] rb;
      cs = 0; w(2*Q);
      spi_byte({1'b1, ms, 6'(addr)}, 1'b1, rb);
      for (int k = 0; k < n; k++) begin
         spi_byte(8'hA5, 1'b0, rb);
         if (ms) chk("R5 read data", rb, model[(addr + k) % NREG]);
         else    chk("R6 read fixed address", rb, model[addr]);
         if (tw_b) begin
            chk("R9 data pad driven", {7'd0, sda_oe_o}, 8'd1);
            chk("R9 sdo off in 3-wire", {7'd0, sdo_oe_o}, 8'd0);
         end else begin
            chk("R8 sdo driven", {7'd0, sdo_oe_o}, 8'd1);
            chk("R8 data pad not driven", {7'd0, sda_oe_o}, 8'd0);
         end
      end
      spi_end();
   endtask

   task automatic spi_write(input int addr, input int n, input bit ms);
      logic [7:0] rb;
      cs = 0; w(2*Q);
      spi_byte({1'b0, ms, 6'(addr)}, 1'b1, rb);
      for (int k = 0; k < n; k++) begin
         spi_byte(wbuf[k], 1'b0, rb);
         model[ms ? (addr + k) % NREG : addr] = wbuf[k];
      end
      spi_end();
      tw_b = model[CFG][0];
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
   end

   initial begin
      logic ack;
      for (int i = 0; i < NREG; i++) model[i] = 8'h00;
      w(4); rst_n = 1; w(4);
      // R10 reset state of pads and registers
      chk("R10 sda_oe after reset", {7'd0, sda_oe_o}, 8'd0);
      chk("R10 sdo_oe after reset", {7'd0, sdo_oe_o}, 8'd0);
      spi_read(0, NREG, 1'b1);

      // R3 burst write over I2C with wrap from 60
      for (int k = 0; k < NREG; k++) wbuf[k] = pat((60 + k) % NREG, 5);
      i2c_write(DEV, 60, NREG);
      // R4 burst read back over I2C with NACK on last byte
      i2c_read(0, NREG);

      // R2 wrong address
      i2c_start();
      i2c_wbyte({DEV ^ 7'h01, 1'b0}, ack);
      chk("R2 wrong address no ack", {7'd0, ack}, 8'd1);
      i2c_wbyte(8'h03, ack);
      i2c_wbyte(8'hAA, ack);
      i2c_stop();
      i2c_read(3, 1);

      // R5 R8 4-wire sweep over SPI
      spi_read(0, NREG, 1'b1);

      // R6 non-incrementing write and read
      wbuf[0] = 8'h11; wbuf[1] = 8'h22;
      spi_write(5, 2, 1'b0);
      spi_read(5, 3, 1'b0);
      spi_read(6, 1, 1'b0);

      // R5 incrementing write across top of map
      for (int k = 0; k < 4; k++) wbuf[k] = 8'hC0 + 8'(k);
      spi_write(62, 4, 1'b1);

      // R7 switch to 3-wire, R9 sweep
      wbuf[0] = 8'h01;
      spi_write(int'(CFG), 1, 1'b0);
      chk("R7 mode bit set", {7'd0, tw_b}, 8'd1);
      spi_read(0, NREG, 1'b1);

      // R1 I2C still works in 3-wire configuration
      i2c_read(int'(CFG), 2);

      // R7 back to 4-wire via I2C
      wbuf[0] = 8'h00;
      i2c_write(DEV, int'(CFG), 1);
      tw_b = 1'b0;
      spi_read(int'(CFG) - 1, 3, 1'b1);

      report();
   end
endmodule